// File: doc/BRIEF.md
# Staged Data Buffer Register Port

This block places a word FIFO behind a single host data register, the way a tape formatter exposes its data buffer for diagnostics. A host write lands in an input holding register. That word moves into the FIFO as soon as the FIFO has room. A host read returns whatever sits in an output holding register. After a read, the output register refills by itself from the next FIFO word. Two ready flags report the state of each side: one says whether the input side can take a word, and the other says whether the output side holds one.

In write-check operation, a compare circuit outside this block signals a mismatch and supplies the tape word that failed. The block loads that word into the output holding register and freezes it there. The host can then read the word as often as it needs, and the stream does not advance. A release input ends the freeze and throws the frozen word away, after which refilling resumes.

Top module: `dbuf_port`

## Requirements
- R1: A synchronous active-high reset empties the FIFO and sets the port flags as follows: `in_rdy`=1, `out_rdy`=0, `overrun`=0, `fifo_empty`=1, `fifo_full`=0, `frozen`=0.
- R2: A host write (`wr_en`=1) while `in_rdy`=1 loads `wr_data` into the input holding register, and `in_rdy` reads 0 after that clock edge.
- R3: A held word moves into the FIFO on the next edge on which the FIFO is not full. `in_rdy` reads 1 after that edge.
- R4: A host write while `in_rdy`=0 is dropped and sets `overrun` to 1. `overrun` then stays 1 until reset.
- R5: Words reach `rd_data` in the order they were written. `fifo_full` is 1 when DEPTH words are stored, so at most DEPTH+2 words are in the block at once.
- R6: When the output register is empty and the FIFO is not, the next word is fetched and loaded, and `out_rdy` rises. For a single write into an empty block, `out_rdy` reads 1 three edges after the write edge.
- R7: A host read (`rd_en`=1) while `out_rdy`=1 and `frozen`=0 consumes the word, and `out_rdy` reads 0 after that edge. A read while `out_rdy`=0 has no effect.
- R8: A `chk_fail` pulse loads `chk_word` into the output register and replaces the word held there, which is lost. After that edge, `frozen`=1 and `out_rdy`=1.
- R9: While `frozen`=1, reads return the frozen word, `out_rdy` stays 1, and nothing is taken from the FIFO.
- R10: A `frz_clr` pulse while frozen clears `frozen` and `out_rdy` and discards the frozen word. The next FIFO word is then loaded as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 16 | Output holding register contents |
| in_rdy | output | 1 | Input holding register can take a word |
| out_rdy | output | 1 | Output holding register holds a word |
| overrun | output | 1 | Sticky flag for a dropped write |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no words |
| chk_fail | input | 1 | Write-check compare mismatch pulse |
| chk_word | input | 16 | Tape word that failed the compare |
| frz_clr | input | 1 | Release of the freeze |
| frozen | output | 1 | Output register is frozen |

## Verification
The assertions check the following on every cycle:
- The FIFO is never pushed when full or popped when empty.
- An accepted write drops `in_rdy`.
- `overrun` never falls without reset.
- A frozen word stays stable until it is released or replaced.

Only the bench scenarios can show these behaviours:
- The end-to-end word order through both holding registers and the FIFO.
- The exact three-edge fill latency.
- The fill count of DEPTH+2.
- That the old output word is lost when a freeze begins.
- That refill resumes with the correct next word after release.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  parameter int unsigned DBUF_W = 16;
  typedef logic [DBUF_W-1:0] dword_t;
endpackage

// File: rtl/dbuf_fifo.sv
module dbuf_fifo
  import dbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   push,
  input  dword_t din,
  input  logic   pop,
  output dword_t dout,
  output logic   full,
  output logic   empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  dword_t        mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  // Write port and registered read port, in the form block RAM inference expects
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
    if (pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == FULLC);
  assign empty = (count == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/dbuf_inreg.sv
module dbuf_inreg
  import dbuf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr_en,
  input  dword_t wr_data,
  input  logic   fifo_full,
  output logic   push,
  output dword_t push_data,
  output logic   in_rdy,
  output logic   overrun
);
  logic   held;
  dword_t hold_q;

  assign push      = held && !fifo_full;
  assign push_data = hold_q;
  assign in_rdy    = !held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      hold_q  <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_en && !held) begin
        hold_q <= wr_data;
        held   <= 1'b1;
      end else if (push) begin
        held <= 1'b0;
      end
      if (wr_en && held) overrun <= 1'b1;
    end
  end

  // R2
  wr_drops_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_rdy) |=> !in_rdy);
  // R4
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

// File: rtl/dbuf_outreg.sv
module dbuf_outreg
  import dbuf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   rd_en,
  input  logic   fifo_empty,
  input  dword_t fifo_dout,
  output logic   pop,
  input  logic   chk_fail,
  input  dword_t chk_word,
  input  logic   frz_clr,
  output dword_t rd_data,
  output logic   out_rdy,
  output logic   frozen
);
  logic   pend;
  dword_t data_q;

  assign pop     = !out_rdy && !pend && !frozen && !fifo_empty && !chk_fail;
  assign rd_data = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      out_rdy <= 1'b0;
      frozen  <= 1'b0;
      data_q  <= '0;
    end else begin
      pend <= pop;
      if (chk_fail) begin
        data_q  <= chk_word;
        out_rdy <= 1'b1;
        frozen  <= 1'b1;
      end else if (frozen) begin
        if (frz_clr) begin
          frozen  <= 1'b0;
          out_rdy <= 1'b0;
        end
      end else if (pend) begin
        data_q  <= fifo_dout;
        out_rdy <= 1'b1;
      end else if (rd_en && out_rdy) begin
        out_rdy <= 1'b0;
      end
    end
  end

  // R9
  frozen_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (frozen && !frz_clr && !chk_fail) |=> ($stable(rd_data) && out_rdy));
  // R8
  freeze_sets_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    chk_fail |=> (frozen && out_rdy));
endmodule

// File: rtl/dbuf_port.sv
module dbuf_port
  import dbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DBUF_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DBUF_W-1:0] rd_data,
  output logic              in_rdy,
  output logic              out_rdy,
  output logic              overrun,
  output logic              fifo_full,
  output logic              fifo_empty,
  input  logic              chk_fail,
  input  logic [DBUF_W-1:0] chk_word,
  input  logic              frz_clr,
  output logic              frozen
);
  logic   push, pop;
  dword_t push_data, fifo_dout;

  dbuf_inreg u_in (
    .clk, .rst, .wr_en, .wr_data, .fifo_full,
    .push, .push_data, .in_rdy, .overrun
  );

  dbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst, .push, .din(push_data), .pop,
    .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
  );

  dbuf_outreg u_out (
    .clk, .rst, .rd_en, .fifo_empty, .fifo_dout, .pop,
    .chk_fail, .chk_word, .frz_clr, .rd_data, .out_rdy, .frozen
  );
endmodule

// File: tb/sim_dbuf_port.sv
module sim_dbuf_port;
  logic        clk = 0, rst = 1;
  logic        wr_en = 0, rd_en = 0, chk_fail = 0, frz_clr = 0;
  logic [15:0] wr_data = '0, chk_word = '0, rd_data;
  logic        in_rdy, out_rdy, overrun, fifo_full, fifo_empty, frozen;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] sb[$];

  always #5 clk = ~clk;

  dbuf_port #(.DEPTH(8)) u0 (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Driver: waits for room, writes, and records the expected word
  task automatic drive(logic [15:0] d);
    for (int i = 0; i < 100 && !in_rdy; i++) @(negedge clk);
    wr_en = 1; wr_data = d; sb.push_back(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  // Monitor: waits for a word, compares it with the queue head, consumes it
  task automatic take(string req);
    logic [15:0] e;
    for (int i = 0; i < 100 && !out_rdy; i++) @(negedge clk);
    e = sb.pop_front();
    check(req, rd_data, e);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    check({req, " rdy drop"}, 16'(out_rdy), 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    check("R1 in_rdy", 16'(in_rdy), 16'd1);
    check("R1 out_rdy", 16'(out_rdy), 16'd0);
    check("R1 overrun", 16'(overrun), 16'd0);
    check("R1 empty", 16'(fifo_empty), 16'd1);
    check("R1 full", 16'(fifo_full), 16'd0);
    check("R1 frozen", 16'(frozen), 16'd0);

    // R7: a read with nothing present has no effect
    rd_en = 1; @(negedge clk); rd_en = 0;
    check("R7 idle read", 16'(out_rdy), 16'd0);

    // R2 R3 R6: cycle-exact path through an empty block
    wr_en = 1; wr_data = 16'h1234; sb.push_back(16'h1234);
    @(negedge clk); wr_en = 0;
    check("R2 in_rdy low", 16'(in_rdy), 16'd0);
    @(negedge clk);
    check("R3 in_rdy back", 16'(in_rdy), 16'd1);
    @(negedge clk);
    check("R6 not yet", 16'(out_rdy), 16'd0);
    @(negedge clk);
    check("R6 out_rdy", 16'(out_rdy), 16'd1);
    take("R7 first word");

    // R5: fill to DEPTH+2, then check order
    for (int k = 0; k < 10; k++) drive(16'hA000 + 16'(k));
    repeat (4) @(negedge clk);
    check("R5 full", 16'(fifo_full), 16'd1);
    check("R5 in_rdy held", 16'(in_rdy), 16'd0);
    check("R4 no overrun yet", 16'(overrun), 16'd0);
    // R4: dropped write
    wr_en = 1; wr_data = 16'hDEAD; @(negedge clk); wr_en = 0;
    check("R4 overrun set", 16'(overrun), 16'd1);
    for (int k = 0; k < 10; k++) take("R5 order");
    repeat (4) @(negedge clk);
    check("R5 empty after drain", 16'(fifo_empty), 16'd1);
    check("R4 overrun sticky", 16'(overrun), 16'd1);

    // R8 R9 R10: freeze and release
    drive(16'h0B0A); drive(16'h0B0B);
    for (int i = 0; i < 20 && !out_rdy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    void'(sb.pop_front());  // word replaced by the freeze is lost
    chk_fail = 1; chk_word = 16'hBAD1; @(negedge clk); chk_fail = 0;
    check("R8 word", rd_data, 16'hBAD1);
    check("R8 frozen", 16'(frozen), 16'd1);
    check("R8 out_rdy", 16'(out_rdy), 16'd1);
    rd_en = 1; @(negedge clk); rd_en = 0;
    check("R9 word kept", rd_data, 16'hBAD1);
    check("R9 out_rdy kept", 16'(out_rdy), 16'd1);
    frz_clr = 1; @(negedge clk); frz_clr = 0;
    check("R10 frozen clr", 16'(frozen), 16'd0);
    check("R10 out_rdy clr", 16'(out_rdy), 16'd0);
    take("R10 next word");
    check("R4 overrun at end", 16'(overrun), 16'd1);
    summary();
  end
endmodule